// File: doc/BRIEF.md
# Parallel Port Controller with External Bus Override

This block holds the output latches of four byte-wide parallel ports in a small microcontroller. It decides, cycle by cycle, how each pin is driven. Each port has one register, which the CPU writes over the internal bus with a per-port write strobe. A read returns either the stored latch byte or the live pin levels. A per-access select input, standing for the instruction type, chooses which.

Pins are modelled without tri-state nets. For every pin the block drives four registered enables: pull low, strong high, weak pullup and float. Exactly one of them is set at any time. In normal operation the bus port (port 0) is open-drain and ports 1 to 3 are quasi-bidirectional.

An external-memory access mode takes over two ports. Port 0 drives the low address byte during the address phase. In the data phase it then drives the write data, or it releases the pins so that read data can be captured. Port 2 drives the high address byte during wide-address accesses. During narrow-address accesses port 2 keeps its own latch. A serial-peripheral override turns selected port 1 pins into push-pull outputs or floating inputs.

Top module: `pport_ctrl`

## Requirements
- R1: A synchronous reset sets every port latch to all ones. The first registered drive state is then float for every port 0 pin and weak pullup for every pin of ports 1 to 3. The read data and the latched address both start at zero.
- R2: With `wr_en` high, the port chosen by `wr_sel` (port number, 0 to 3) stores `wr_data` at the clock edge. The other ports keep their values. A later latch read (`rd_pin`=0) of that port returns the stored byte one cycle after the request.
- R3: A read with `rd_pin`=1 returns the pin-input byte of the selected port, one cycle after the request. A read with `rd_pin`=0 returns the latch whatever the pins show. Port p occupies bits p*8+7 down to p*8 of every pin vector.
- R4: Outside external access, a port 0 pin with latch 0 is pulled low and a pin with latch 1 floats. Port 0 never drives strong high in this case.
- R5: On ports 1 to 3, a pin with latch 0 is pulled low and a pin with latch 1 gets the weak pullup, unless an override below applies.
- R6: In every cycle after reset, each pin has exactly one of its four drive enables set. Drive enables follow their inputs with one cycle of latency.
- R7: In the address phase of an external access (`ext_en`=1, `ext_addr_phase`=1), port 0 drives `ext_addr[7:0]` push-pull: strong high for 1 bits and pulled low for 0 bits.
- R8: In the data phase of an external access, port 0 drives `ext_wdata` push-pull when `ext_wr`=1. When `ext_wr`=0 it floats all pins, and `ext_rdata` captures the port 0 pin byte at the clock edge.
- R9: During an external access with `ext_wide`=1, port 2 drives `ext_addr[15:8]` push-pull. With `ext_wide`=0, port 2 keeps its quasi-bidirectional behaviour from its latch.
- R10: When the address phase of an external access ends, `addr_lat` takes `ext_addr[7:0]` at that clock edge and holds it until the next such event.
- R11: With `ser_en`=1, each port 1 pin whose bit is set in `SER_MASK` (default 8'h0F) is controlled as follows. If its `ser_oe` bit is 1 it drives the matching `ser_out` bit push-pull. If its `ser_oe` bit is 0 it floats. The other port 1 pins stay quasi-bidirectional, and `ser_oe`/`ser_out` bits outside the mask have no effect on them.
- R12: External accesses never change any port latch. Once `ext_en` falls, ports 0 and 2 return to their normal drive from the unchanged latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 2 | Port number to write |
| wr_data | input | 8 | Internal bus write byte |
| rd_sel | input | 2 | Port number to read |
| rd_pin | input | 1 | 1 = read pins, 0 = read latch |
| rd_data | output | 8 | Registered read result |
| pin_in | input | 32 | Sampled pin levels, all ports |
| ext_en | input | 1 | External memory access active |
| ext_addr_phase | input | 1 | 1 = address phase, 0 = data phase |
| ext_wide | input | 1 | 1 = 16-bit address access |
| ext_wr | input | 1 | 1 = external write, 0 = external read |
| ext_addr | input | 16 | External address |
| ext_wdata | input | 8 | External write data |
| ext_rdata | output | 8 | Captured external read data |
| addr_lat | output | 8 | Low address latched at end of address phase |
| ser_en | input | 1 | Serial-peripheral override enable |
| ser_oe | input | 8 | Serial output enable per port 1 bit |
| ser_out | input | 8 | Serial output value per port 1 bit |
| drv_low | output | 32 | Per-pin pull-low enable |
| drv_high | output | 32 | Per-pin strong-high enable |
| drv_weak | output | 32 | Per-pin weak-pullup enable |
| drv_float | output | 32 | Per-pin float enable |

## Verification
The bench checks that a latch read and a pin read of the same port return different bytes when the pins disagree. A design that wired both read paths to one source would return the same value for both. It drives the bus port through address, write-data and read-data phases. A design that stayed open-drain in bus mode would float the 1 bits instead of driving them high, and one that failed to release would block captured read data. Narrow and wide accesses are both run, so a design that always or never hands port 2 to the high address is caught. The serial override is driven with enables set outside the mask, and latches are read back after bus traffic, which exposes any override that leaks into neighbouring pins or writes into the latches.

// File: rtl/pport_pkg.sv
package pport_pkg;

  // Per-pin drive personality chosen each cycle
  typedef enum logic [1:0] {
    PM_OPEN_DRAIN = 2'd0,
    PM_QUASI      = 2'd1,
    PM_PUSH_PULL  = 2'd2,
    PM_RELEASE    = 2'd3
  } pin_mode_e;

  // One-hot drive enables of a single pin
  typedef struct packed {
    logic pull_low;
    logic drive_high;
    logic pull_weak;
    logic hi_z;
  } pin_drv_t;

  function automatic pin_drv_t encode_pin(pin_mode_e mode, logic val);
    pin_drv_t d;
    d = '0;
    case (mode)
      PM_OPEN_DRAIN: if (val) d.hi_z = 1'b1;       else d.pull_low = 1'b1;
      PM_QUASI:      if (val) d.pull_weak = 1'b1;  else d.pull_low = 1'b1;
      PM_PUSH_PULL:  if (val) d.drive_high = 1'b1; else d.pull_low = 1'b1;
      default:       d.hi_z = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pport_latch_bank.sv
module pport_latch_bank #(
  parameter int NUM_PORTS = 4,
  parameter int WIDTH     = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic [$clog2(NUM_PORTS)-1:0]          wr_sel,
  input  logic [WIDTH-1:0]                      wr_data,
  output logic [NUM_PORTS-1:0][WIDTH-1:0]       latch_q
);
  localparam int SEL_W = $clog2(NUM_PORTS);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        latch_q[p] <= '1;
      end else if (wr_en && (wr_sel == SEL_W'(p))) begin
        latch_q[p] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/pport_mode_sel.sv
module pport_mode_sel
  import pport_pkg::*;
#(
  parameter int               NUM_PORTS = 4,
  parameter int               WIDTH     = 8,
  parameter int               BUS_PORT  = 0,
  parameter int               HI_PORT   = 2,
  parameter int               SER_PORT  = 1,
  parameter logic [WIDTH-1:0] SER_MASK  = 'h0F
) (
  input  logic [NUM_PORTS-1:0][WIDTH-1:0]        latch_q,
  input  logic                                   ext_en,
  input  logic                                   ext_addr_phase,
  input  logic                                   ext_wide,
  input  logic                                   ext_wr,
  input  logic [2*WIDTH-1:0]                     ext_addr,
  input  logic [WIDTH-1:0]                       ext_wdata,
  input  logic                                   ser_en,
  input  logic [WIDTH-1:0]                       ser_oe,
  input  logic [WIDTH-1:0]                       ser_out,
  output pin_mode_e [NUM_PORTS-1:0][WIDTH-1:0]   mode_o,
  output logic [NUM_PORTS-1:0][WIDTH-1:0]        val_o
);

  always_comb begin
    // Default personalities from the latches
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int b = 0; b < WIDTH; b++) begin
        mode_o[p][b] = (p == BUS_PORT) ? PM_OPEN_DRAIN : PM_QUASI;
        val_o[p][b]  = latch_q[p][b];
      end
    end

    // External memory bus takes over the bus port and, if wide, the high port
    if (ext_en) begin
      for (int b = 0; b < WIDTH; b++) begin
        if (ext_addr_phase) begin
          mode_o[BUS_PORT][b] = PM_PUSH_PULL;
          val_o[BUS_PORT][b]  = ext_addr[b];
        end else if (ext_wr) begin
          mode_o[BUS_PORT][b] = PM_PUSH_PULL;
          val_o[BUS_PORT][b]  = ext_wdata[b];
        end else begin
          mode_o[BUS_PORT][b] = PM_RELEASE;
          val_o[BUS_PORT][b]  = 1'b1;
        end
        if (ext_wide) begin
          mode_o[HI_PORT][b] = PM_PUSH_PULL;
          val_o[HI_PORT][b]  = ext_addr[WIDTH+b];
        end
      end
    end

    // Serial peripheral pins on the serial port
    if (ser_en) begin
      for (int b = 0; b < WIDTH; b++) begin
        if (SER_MASK[b]) begin
          mode_o[SER_PORT][b] = ser_oe[b] ? PM_PUSH_PULL : PM_RELEASE;
          val_o[SER_PORT][b]  = ser_out[b];
        end
      end
    end
  end
endmodule

// File: rtl/pport_drive_enc.sv
module pport_drive_enc
  import pport_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int WIDTH     = 8,
  parameter int BUS_PORT  = 0
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  pin_mode_e [NUM_PORTS-1:0][WIDTH-1:0]   mode_i,
  input  logic [NUM_PORTS-1:0][WIDTH-1:0]        val_i,
  output logic [NUM_PORTS*WIDTH-1:0]             drv_low,
  output logic [NUM_PORTS*WIDTH-1:0]             drv_high,
  output logic [NUM_PORTS*WIDTH-1:0]             drv_weak,
  output logic [NUM_PORTS*WIDTH-1:0]             drv_float
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    // Reset drive matches an all-ones latch in normal mode
    localparam pin_drv_t RST_DRV = (p == BUS_PORT) ?
                                   encode_pin(PM_OPEN_DRAIN, 1'b1) :
                                   encode_pin(PM_QUASI, 1'b1);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      localparam int IDX = p*WIDTH + b;
      pin_drv_t nxt, cur;
      assign nxt = encode_pin(mode_i[p][b], val_i[p][b]);
      always_ff @(posedge clk) begin
        if (rst) cur <= RST_DRV;
        else     cur <= nxt;
      end
      assign drv_low[IDX]   = cur.pull_low;
      assign drv_high[IDX]  = cur.drive_high;
      assign drv_weak[IDX]  = cur.pull_weak;
      assign drv_float[IDX] = cur.hi_z;
    end
  end
endmodule

// File: rtl/pport_bus_cap.sv
module pport_bus_cap #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_en,
  input  logic             ext_addr_phase,
  input  logic             ext_wr,
  input  logic [WIDTH-1:0] addr_lo,
  input  logic [WIDTH-1:0] bus_pins,
  output logic [WIDTH-1:0] ext_rdata,
  output logic [WIDTH-1:0] addr_lat
);
  logic phase_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_d   <= 1'b0;
      ext_rdata <= '0;
      addr_lat  <= '0;
    end else begin
      phase_d <= ext_en && ext_addr_phase;
      if (ext_en && phase_d && !ext_addr_phase)
        addr_lat <= addr_lo;
      if (ext_en && !ext_addr_phase && !ext_wr)
        ext_rdata <= bus_pins;
    end
  end
endmodule

// File: rtl/pport_read_port.sv
module pport_read_port #(
  parameter int NUM_PORTS = 4,
  parameter int WIDTH     = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [$clog2(NUM_PORTS)-1:0]       rd_sel,
  input  logic                               rd_pin,
  input  logic [NUM_PORTS-1:0][WIDTH-1:0]    latch_q,
  input  logic [NUM_PORTS*WIDTH-1:0]         pin_in,
  output logic [WIDTH-1:0]                   rd_data
);
  logic [NUM_PORTS-1:0][WIDTH-1:0] pins_by_port;
  assign pins_by_port = pin_in;

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_pin) rd_data <= pins_by_port[rd_sel];
    else             rd_data <= latch_q[rd_sel];
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int               NUM_PORTS = 4,
  parameter int               WIDTH     = 8,
  parameter int               BUS_PORT  = 0,
  parameter int               HI_PORT   = 2,
  parameter int               SER_PORT  = 1,
  parameter logic [WIDTH-1:0] SER_MASK  = 'h0F
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [$clog2(NUM_PORTS)-1:0]      wr_sel,
  input  logic [WIDTH-1:0]                  wr_data,
  input  logic [$clog2(NUM_PORTS)-1:0]      rd_sel,
  input  logic                              rd_pin,
  output logic [WIDTH-1:0]                  rd_data,
  input  logic [NUM_PORTS*WIDTH-1:0]        pin_in,
  input  logic                              ext_en,
  input  logic                              ext_addr_phase,
  input  logic                              ext_wide,
  input  logic                              ext_wr,
  input  logic [2*WIDTH-1:0]                ext_addr,
  input  logic [WIDTH-1:0]                  ext_wdata,
  output logic [WIDTH-1:0]                  ext_rdata,
  output logic [WIDTH-1:0]                  addr_lat,
  input  logic                              ser_en,
  input  logic [WIDTH-1:0]                  ser_oe,
  input  logic [WIDTH-1:0]                  ser_out,
  output logic [NUM_PORTS*WIDTH-1:0]        drv_low,
  output logic [NUM_PORTS*WIDTH-1:0]        drv_high,
  output logic [NUM_PORTS*WIDTH-1:0]        drv_weak,
  output logic [NUM_PORTS*WIDTH-1:0]        drv_float
);

  logic [NUM_PORTS-1:0][WIDTH-1:0]      latch_q;
  pin_mode_e [NUM_PORTS-1:0][WIDTH-1:0] pin_mode;
  logic [NUM_PORTS-1:0][WIDTH-1:0]      pin_val;

  pport_latch_bank #(.NUM_PORTS(NUM_PORTS), .WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .latch_q(latch_q)
  );

  pport_mode_sel #(
    .NUM_PORTS(NUM_PORTS), .WIDTH(WIDTH), .BUS_PORT(BUS_PORT),
    .HI_PORT(HI_PORT), .SER_PORT(SER_PORT), .SER_MASK(SER_MASK)
  ) u_mode (
    .latch_q(latch_q), .ext_en(ext_en), .ext_addr_phase(ext_addr_phase),
    .ext_wide(ext_wide), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ser_en(ser_en), .ser_oe(ser_oe),
    .ser_out(ser_out), .mode_o(pin_mode), .val_o(pin_val)
  );

  pport_drive_enc #(.NUM_PORTS(NUM_PORTS), .WIDTH(WIDTH), .BUS_PORT(BUS_PORT)) u_enc (
    .clk(clk), .rst(rst), .mode_i(pin_mode), .val_i(pin_val),
    .drv_low(drv_low), .drv_high(drv_high),
    .drv_weak(drv_weak), .drv_float(drv_float)
  );

  pport_bus_cap #(.WIDTH(WIDTH)) u_bus (
    .clk(clk), .rst(rst), .ext_en(ext_en), .ext_addr_phase(ext_addr_phase),
    .ext_wr(ext_wr), .addr_lo(ext_addr[WIDTH-1:0]),
    .bus_pins(pin_in[BUS_PORT*WIDTH +: WIDTH]),
    .ext_rdata(ext_rdata), .addr_lat(addr_lat)
  );

  pport_read_port #(.NUM_PORTS(NUM_PORTS), .WIDTH(WIDTH)) u_read (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_pin(rd_pin),
    .latch_q(latch_q), .pin_in(pin_in), .rd_data(rd_data)
  );
endmodule

// File: rtl/pport_checker.sv
module pport_checker #(
  parameter int               NUM_PORTS = 4,
  parameter int               WIDTH     = 8,
  parameter int               BUS_PORT  = 0,
  parameter int               HI_PORT   = 2,
  parameter int               SER_PORT  = 1,
  parameter logic [WIDTH-1:0] SER_MASK  = 'h0F
) (
  input logic                          clk,
  input logic                          rst,
  input logic [WIDTH-1:0]              rd_data,
  input logic                          ext_en,
  input logic                          ext_addr_phase,
  input logic                          ext_wide,
  input logic                          ext_wr,
  input logic [2*WIDTH-1:0]            ext_addr,
  input logic [WIDTH-1:0]              addr_lat,
  input logic [NUM_PORTS*WIDTH-1:0]    drv_low,
  input logic [NUM_PORTS*WIDTH-1:0]    drv_high,
  input logic [NUM_PORTS*WIDTH-1:0]    drv_weak,
  input logic [NUM_PORTS*WIDTH-1:0]    drv_float
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0) && (addr_lat == '0));

  for (genvar i = 0; i < NUM_PORTS*WIDTH; i++) begin : g_onehot
    assert_one_drive_R6: assert property (@(posedge clk) disable iff (rst)
      $countones({drv_low[i], drv_high[i], drv_weak[i], drv_float[i]}) == 1);
  end

  assert_od_no_strong_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(ext_en) |-> (drv_high[BUS_PORT*WIDTH +: WIDTH] == '0));

  assert_quasi_no_strong_R5: assert property (@(posedge clk) disable iff (rst)
    (drv_high[SER_PORT*WIDTH +: WIDTH] & ~SER_MASK) == '0);

  assert_addr_drive_R7: assert property (@(posedge clk) disable iff (rst)
    $past(ext_en && ext_addr_phase) |->
      (drv_high[BUS_PORT*WIDTH +: WIDTH] == $past(ext_addr[WIDTH-1:0])) &&
      (drv_low[BUS_PORT*WIDTH +: WIDTH] == ~$past(ext_addr[WIDTH-1:0])));

  assert_read_release_R8: assert property (@(posedge clk) disable iff (rst)
    $past(ext_en && !ext_addr_phase && !ext_wr) |->
      (drv_float[BUS_PORT*WIDTH +: WIDTH] == '1));

  assert_high_addr_R9: assert property (@(posedge clk) disable iff (rst)
    $past(ext_en && ext_wide) |->
      (drv_high[HI_PORT*WIDTH +: WIDTH] == $past(ext_addr[2*WIDTH-1:WIDTH])));

  assert_addr_latch_R10: assert property (@(posedge clk) disable iff (rst)
    (ext_en && $fell(ext_addr_phase)) |=> (addr_lat == $past(ext_addr[WIDTH-1:0])));

endmodule

bind pport_ctrl pport_checker #(
  .NUM_PORTS(NUM_PORTS), .WIDTH(WIDTH), .BUS_PORT(BUS_PORT),
  .HI_PORT(HI_PORT), .SER_PORT(SER_PORT), .SER_MASK(SER_MASK)
) u_pport_checker (
  .clk(clk), .rst(rst), .rd_data(rd_data), .ext_en(ext_en),
  .ext_addr_phase(ext_addr_phase), .ext_wide(ext_wide), .ext_wr(ext_wr),
  .ext_addr(ext_addr), .addr_lat(addr_lat), .drv_low(drv_low),
  .drv_high(drv_high), .drv_weak(drv_weak), .drv_float(drv_float)
);

// File: tb/tb_pport_ctrl.sv
module tb_pport_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [1:0]  rd_sel;
  logic        rd_pin;
  logic [7:0]  rd_data;
  logic [31:0] pin_in;
  logic        ext_en, ext_addr_phase, ext_wide, ext_wr;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata, ext_rdata, addr_lat;
  logic        ser_en;
  logic [7:0]  ser_oe, ser_out;
  logic [31:0] drv_low, drv_high, drv_weak, drv_float;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pport_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_pin(rd_pin), .rd_data(rd_data), .pin_in(pin_in),
    .ext_en(ext_en), .ext_addr_phase(ext_addr_phase), .ext_wide(ext_wide),
    .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .ext_rdata(ext_rdata), .addr_lat(addr_lat), .ser_en(ser_en),
    .ser_oe(ser_oe), .ser_out(ser_out), .drv_low(drv_low),
    .drv_high(drv_high), .drv_weak(drv_weak), .drv_float(drv_float)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare the four drive vectors of one port
  task automatic chk_drv(string req, int p, logic [7:0] lo, logic [7:0] hi,
                         logic [7:0] wk, logic [7:0] fl);
    chk({req, " low"},   {24'h0, drv_low[p*8 +: 8]},   {24'h0, lo});
    chk({req, " high"},  {24'h0, drv_high[p*8 +: 8]},  {24'h0, hi});
    chk({req, " weak"},  {24'h0, drv_weak[p*8 +: 8]},  {24'h0, wk});
    chk({req, " float"}, {24'h0, drv_float[p*8 +: 8]}, {24'h0, fl});
  endtask

  task automatic chk_onehot(string req);
    for (int i = 0; i < 32; i++)
      chk(req, 32'($countones({drv_low[i], drv_high[i], drv_weak[i], drv_float[i]})), 32'd1);
  endtask

  task automatic write_port(logic [1:0] p, logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = p; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);   // drive register has followed the latch
  endtask

  task automatic read_port(logic [1:0] p, logic pin, output logic [7:0] v);
    @(negedge clk);
    rd_sel = p; rd_pin = pin;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 rd_data", {24'h0, rd_data}, 32'h0);
    chk("R1 addr_lat", {24'h0, addr_lat}, 32'h0);
    chk_drv("R1 p0", 0, 8'h00, 8'h00, 8'h00, 8'hFF);
    for (int p = 1; p < 4; p++) chk_drv("R1 quasi", p, 8'h00, 8'h00, 8'hFF, 8'h00);
    for (int p = 0; p < 4; p++) begin
      read_port(2'(p), 1'b0, v);
      chk("R1 latch ones", {24'h0, v}, 32'hFF);
    end
  endtask

  task automatic t_write_read();
    logic [7:0] v;
    write_port(2'd0, 8'hA5);
    write_port(2'd1, 8'h3C);
    read_port(2'd2, 1'b0, v);
    chk("R2 untouched p2", {24'h0, v}, 32'hFF);
    write_port(2'd2, 8'h0F);
    write_port(2'd3, 8'hF0);
    read_port(2'd0, 1'b0, v); chk("R2 p0", {24'h0, v}, 32'hA5);
    read_port(2'd1, 1'b0, v); chk("R2 p1", {24'h0, v}, 32'h3C);
    read_port(2'd2, 1'b0, v); chk("R2 p2", {24'h0, v}, 32'h0F);
    read_port(2'd3, 1'b0, v); chk("R2 p3", {24'h0, v}, 32'hF0);
  endtask

  task automatic t_pin_read();
    logic [7:0] v;
    pin_in = 32'h6E_81_C3_17;
    read_port(2'd0, 1'b1, v); chk("R3 pin p0", {24'h0, v}, 32'h17);
    read_port(2'd1, 1'b1, v); chk("R3 pin p1", {24'h0, v}, 32'hC3);
    read_port(2'd3, 1'b1, v); chk("R3 pin p3", {24'h0, v}, 32'h6E);
    read_port(2'd1, 1'b0, v); chk("R3 latch not pins", {24'h0, v}, 32'h3C);
  endtask

  task automatic t_normal_drive();
    chk_drv("R4 p0 open-drain", 0, 8'h5A, 8'h00, 8'h00, 8'hA5);
    chk_drv("R5 p1 quasi", 1, 8'hC3, 8'h00, 8'h3C, 8'h00);
    chk_drv("R5 p3 quasi", 3, 8'h0F, 8'h00, 8'hF0, 8'h00);
    chk_onehot("R6 one enable");
  endtask

  task automatic t_ext_write_wide();
    @(negedge clk);
    ext_en = 1'b1; ext_addr_phase = 1'b1; ext_wide = 1'b1; ext_wr = 1'b1;
    ext_addr = 16'h12C4; ext_wdata = 8'h9B;
    @(negedge clk);
    chk_drv("R7 addr phase p0", 0, 8'h3B, 8'hC4, 8'h00, 8'h00);
    chk_drv("R9 wide p2", 2, 8'hED, 8'h12, 8'h00, 8'h00);
    chk_onehot("R6 bus mode");
    ext_addr_phase = 1'b0;
    @(negedge clk);
    chk("R10 addr_lat", {24'h0, addr_lat}, 32'hC4);
    chk_drv("R8 write data p0", 0, 8'h64, 8'h9B, 8'h00, 8'h00);
  endtask

  task automatic t_ext_read_narrow();
    @(negedge clk);
    ext_en = 1'b1; ext_addr_phase = 1'b1; ext_wide = 1'b0; ext_wr = 1'b0;
    ext_addr = 16'h3456;
    @(negedge clk);
    chk_drv("R7 addr phase read", 0, 8'hA9, 8'h56, 8'h00, 8'h00);
    chk_drv("R9 narrow p2 quasi", 2, 8'hF0, 8'h00, 8'h0F, 8'h00);
    ext_addr_phase = 1'b0;
    pin_in[7:0] = 8'hE7;
    @(negedge clk);
    chk_drv("R8 read release p0", 0, 8'h00, 8'h00, 8'h00, 8'hFF);
    chk("R8 rdata capture", {24'h0, ext_rdata}, 32'hE7);
    chk("R10 addr_lat read", {24'h0, addr_lat}, 32'h56);
  endtask

  task automatic t_after_ext();
    logic [7:0] v;
    @(negedge clk);
    ext_en = 1'b0; ext_wide = 1'b0;
    @(negedge clk);
    chk_drv("R12 p0 back", 0, 8'h5A, 8'h00, 8'h00, 8'hA5);
    chk_drv("R12 p2 back", 2, 8'hF0, 8'h00, 8'h0F, 8'h00);
    read_port(2'd0, 1'b0, v); chk("R12 latch p0", {24'h0, v}, 32'hA5);
    read_port(2'd2, 1'b0, v); chk("R12 latch p2", {24'h0, v}, 32'h0F);
  endtask

  task automatic t_serial();
    logic [7:0] v;
    @(negedge clk);
    ser_en = 1'b1; ser_oe = 8'hF5; ser_out = 8'hF1;
    @(negedge clk);
    // mask 0F: bit0 high, bit2 low, bits1,3 float; bits4-7 quasi from 3C
    chk_drv("R11 serial p1", 1, 8'hC4, 8'h01, 8'h30, 8'h0A);
    chk_onehot("R6 serial");
    read_port(2'd1, 1'b0, v); chk("R11 latch kept", {24'h0, v}, 32'h3C);
    @(negedge clk);
    ser_en = 1'b0;
    @(negedge clk);
    chk_drv("R11 serial off", 1, 8'hC3, 8'h00, 8'h3C, 8'h00);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0; rd_pin = 1'b0;
    pin_in = '0; ext_en = 1'b0; ext_addr_phase = 1'b0; ext_wide = 1'b0; ext_wr = 1'b0;
    ext_addr = '0; ext_wdata = '0; ser_en = 1'b0; ser_oe = '0; ser_out = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_pin_read();
    t_normal_drive();
    t_ext_write_wide();
    t_ext_read_narrow();
    t_after_ext();
    t_serial();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule